// File: doc/BRIEF.md
# Bus Arbiter with Grant Timeout

This block is the central arbiter of a shared parallel bus with six initiators. Each initiator raises an active-low request and receives an active-low grant. The arbiter watches the bus's active-low frame and initiator-ready lines to see whether a granted initiator actually starts a transaction. A grant that goes unanswered for a fixed window is withdrawn. The arbiter then returns to parking, and the unresponsive initiator is not credited as a bus user.

The arbiter remembers the last initiator that really drove the bus. That memory sets a rotating priority and chooses the parking target when nobody is requesting. Every asserted request is treated as genuine. An initiator that keeps requesting without ever answering is therefore granted again for a fresh window. If another initiator is waiting, that initiator is served first.

Top module: `grant_timeout_arbiter`

## Requirements
- R1: While reset is asserted, all six grant outputs are high (1). After reset, with no request pending, the grant is parked on initiator 0: `gnt_n` equals 6'b111110.
- R2: At most one grant output is low at any clock. When the grant moves between two initiators, there is at least one clock in which no grant is low.
- R3: Requests are registered on one clock edge and acted on at the next. Initiator i is granted when `gnt_n[i]` is 0. If a request is seen at edge n and the grant is parked elsewhere, the parked grant drops at edge n+1 and the requester's grant is asserted at edge n+2.
- R4: The winner is the first requesting index found by counting upward from the last active master plus one, modulo 6. The last active master itself has the lowest priority.
- R5: A grant given in answer to a request is withdrawn after exactly 16 clocks if `frame_n` is never sampled low during that window.
- R6: If `frame_n` is sampled low while a grant is held, the grant holder becomes the last active master. The grant stays on it beyond the window until `frame_n` and `irdy_n` are both sampled high. The grant then drops, and parking follows on that master.
- R7: An initiator whose grant times out is not recorded. The last active master stays as before, and with no request pending the grant parks on it again after one clock with no grant.
- R8: A timed-out initiator that is still the only requester is granted again after a single clock with no grant, for a new full 16-clock window.
- R9: In the arbitration right after a timeout, any other requesting initiator wins over the initiator that just timed out, whatever the rotating priority.
- R10: Dropping a request after its grant has been given does not shorten the window. The grant stays for the full 16 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 6 | Active-low request, one bit per initiator |
| frame_n | input | 1 | Active-low bus frame, low while a transaction runs |
| irdy_n | input | 1 | Active-low initiator-ready of the bus |
| gnt_n | output | 6 | Active-low grant, one bit per initiator |

## Verification
The checks on the last active master assume two things: `frame_n` is driven low only by the initiator holding the grant, and a transaction that starts ends with both `frame_n` and `irdy_n` returning high. The stimulus obeys both. The bench drives frame only after it has seen the expected grant, and it ends every transaction by releasing frame first and initiator-ready one clock later. Requests and bus lines change only on falling clock edges, so every sampled value is stable at the rising edge. Initiators that ignore their grant are modelled by never driving frame, or by driving it only after the window has closed.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_PARK = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } arb_state_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_INIT = 6,
  parameter int IDW      = 3
) (
  input  logic [NUM_INIT-1:0] req,
  input  logic [IDW-1:0]      last,
  output logic                valid,
  output logic [IDW-1:0]      win
);

  // Scan from farthest to nearest so the nearest requester after 'last' wins.
  always_comb begin
    valid = 1'b0;
    win   = '0;
    for (int k = NUM_INIT; k >= 1; k--) begin
      int j;
      j = int'(last) + k;
      if (j >= NUM_INIT) j = j - NUM_INIT;
      if (req[j]) begin
        valid = 1'b1;
        win   = IDW'(j);
      end
    end
  end

endmodule

// File: rtl/arb_wait_timer.sv
module arb_wait_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ld;

  always_comb begin
    cnt_ld = clr | en;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CW'(TIMEOUT - 1));

endmodule

// File: rtl/grant_timeout_arbiter.sv
module grant_timeout_arbiter #(
  parameter int NUM_INIT = 6,
  parameter int TIMEOUT  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INIT-1:0] req_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  output logic [NUM_INIT-1:0] gnt_n
);

  import arb_pkg::*;

  localparam int IDW = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1;

  logic                rst_sync_n;
  logic [NUM_INIT-1:0] req_q;
  logic [NUM_INIT-1:0] eff_req;
  logic [NUM_INIT-1:0] req_unmasked;
  logic                win_vld;
  logic [IDW-1:0]      win_idx;
  logic [NUM_INIT-1:0] win_oh, lam_oh, own_oh;
  logic                tmr_clr, tmr_en, tmr_exp;

  arb_state_e          st_q, st_d;
  logic [NUM_INIT-1:0] gnt_q, gnt_d;
  logic [IDW-1:0]      own_q, own_d;
  logic [IDW-1:0]      lam_q, lam_d;
  logic [NUM_INIT-1:0] mask_q, mask_d;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Request sampling register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) req_q <= '0;
    else             req_q <= ~req_n;
  end

  // Right after a timeout the timed-out initiator steps aside if others wait
  always_comb begin
    req_unmasked = req_q & ~mask_q;
    eff_req      = (|req_unmasked) ? req_unmasked : req_q;
  end

  arb_rr_pick #(.NUM_INIT(NUM_INIT), .IDW(IDW)) u_pick (
    .req   (eff_req),
    .last  (lam_q),
    .valid (win_vld),
    .win   (win_idx)
  );

  arb_wait_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .expired (tmr_exp)
  );

  always_comb begin
    win_oh = NUM_INIT'(1) << win_idx;
    lam_oh = NUM_INIT'(1) << lam_q;
    own_oh = NUM_INIT'(1) << own_q;
  end

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    gnt_d   = gnt_q;
    own_d   = own_q;
    lam_d   = lam_q;
    mask_d  = '0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    unique case (st_q)
      ST_PARK: begin
        if ((gnt_q != '0) && !frame_n) begin
          st_d  = ST_BUSY;
          lam_d = own_q;
        end else if (win_vld) begin
          if (gnt_q == '0) begin
            gnt_d   = win_oh;
            own_d   = win_idx;
            st_d    = ST_WAIT;
            tmr_clr = 1'b1;
          end else if (gnt_q == win_oh) begin
            st_d    = ST_WAIT;
            tmr_clr = 1'b1;
          end else begin
            gnt_d = '0;
          end
        end else if (gnt_q == '0) begin
          gnt_d = lam_oh;
          own_d = lam_q;
        end
      end
      ST_WAIT: begin
        if (!frame_n) begin
          st_d  = ST_BUSY;
          lam_d = own_q;
        end else if (tmr_exp) begin
          gnt_d  = '0;
          st_d   = ST_PARK;
          mask_d = own_oh;
        end else begin
          tmr_en = 1'b1;
        end
      end
      ST_BUSY: begin
        if (frame_n && irdy_n) begin
          gnt_d = '0;
          st_d  = ST_PARK;
        end
      end
      default: st_d = ST_PARK;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_PARK;
      gnt_q  <= '0;
      own_q  <= '0;
      lam_q  <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      gnt_q  <= gnt_d;
      own_q  <= own_d;
      lam_q  <= lam_d;
      mask_q <= mask_d;
    end
  end

  assign gnt_n = ~gnt_q;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_INIT = 6,
  parameter int TIMEOUT  = 16,
  parameter int IDW      = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_INIT-1:0] gnt_n,
  input logic                frame_n,
  input logic                in_wait,
  input logic [IDW-1:0]      lam
);

  localparam int WW = $clog2(TIMEOUT + 1) + 1;

  logic [WW-1:0]       wlen_q;
  logic [IDW-1:0]      lam_prev;
  logic [NUM_INIT-1:0] gnt_prev;
  logic                frm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlen_q   <= '0;
      lam_prev <= '0;
      gnt_prev <= '1;
      frm_prev <= 1'b1;
    end else begin
      wlen_q   <= in_wait ? ((wlen_q == '1) ? wlen_q : wlen_q + 1'b1) : '0;
      lam_prev <= lam;
      gnt_prev <= gnt_n;
      frm_prev <= frame_n;
    end
  end

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  assert_handoff_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(gnt_n) != '0) && (~gnt_n != '0)) |-> (gnt_n == $past(gnt_n)));

  assert_wait_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (int'(wlen_q) < TIMEOUT));

  assert_lam_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lam != lam_prev) |-> (!frm_prev && !gnt_prev[lam]));

endmodule

bind grant_timeout_arbiter arb_checker #(
  .NUM_INIT (NUM_INIT),
  .TIMEOUT  (TIMEOUT),
  .IDW      (IDW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .gnt_n   (gnt_n),
  .frame_n (frame_n),
  .in_wait (st_q == arb_pkg::ST_WAIT),
  .lam     (lam_q)
);

// File: tb/grant_timeout_arbiter_bench.sv
module grant_timeout_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] req_n;
  logic       frame_n;
  logic       irdy_n;
  logic [5:0] gnt_n;
  int         total = 0;
  int         bad   = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  grant_timeout_arbiter u_grant_timeout_arbiter (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n)
  );

  localparam logic [5:0] NONE = 6'h3f;

  function automatic logic [5:0] g(input int i);
    return ~(6'b1 << i);
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s gnt_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nedges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Make initiator l the last active master via one short transaction
  task automatic set_lam(input int l);
    req_n = g(l);
    nedges(3);
    chk("R3 grant to requester", gnt_n, g(l));
    req_n   = NONE;
    frame_n = 1'b0;
    irdy_n  = 1'b0;
    nedges(1);
    frame_n = 1'b1;
    nedges(1);
    chk("R6 grant held while busy", gnt_n, g(l));
    irdy_n = 1'b1;
    nedges(3);
    chk("R6 parks on new owner", gnt_n, g(l));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    req_n   = NONE;
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    nedges(3);
    chk("R1 no grant in reset", gnt_n, NONE);
    rst_n = 1'b1;
    nedges(6);
    chk("R1 park on 0", gnt_n, g(0));

    // Timeout, retry, dropped request (R3 R5 R8 R10 R7)
    req_n = g(4);
    for (int k = 1; k <= 37; k++) begin
      logic [5:0] e;
      nedges(1);
      if (k == 1)       e = g(0);
      else if (k == 2)  e = NONE;
      else if (k <= 18) e = g(4);
      else if (k == 19) e = NONE;
      else if (k <= 35) e = g(4);
      else if (k == 36) e = NONE;
      else              e = g(0);
      if (k <= 3)       chk("R3 request latency", gnt_n, e);
      else if (k <= 19) chk("R5 sixteen clock window", gnt_n, e);
      else if (k == 20) chk("R8 regrant after timeout", gnt_n, e);
      else if (k <= 36) chk("R10 window not shortened", gnt_n, e);
      else              chk("R7 park keeps old owner", gnt_n, e);
      if (k == 20) req_n = NONE;
    end

    // Other requester wins after timeout (R9)
    req_n = g(1);
    nedges(3);
    chk("R4 priority from lam 0", gnt_n, g(1));
    nedges(2);
    req_n = ~6'b000110;
    nedges(14);
    chk("R5 timeout with contender", gnt_n, NONE);
    nedges(1);
    chk("R9 contender served first", gnt_n, g(2));
    req_n = NONE;
    nedges(17);
    chk("R7 lam unchanged after two timeouts", gnt_n, g(0));

    // Frame one clock too late (R7)
    req_n = g(3);
    nedges(3);
    chk("R3 grant 3", gnt_n, g(3));
    req_n = NONE;
    nedges(16);
    chk("R5 grant 3 withdrawn", gnt_n, NONE);
    frame_n = 1'b0;
    nedges(1);
    frame_n = 1'b1;
    nedges(2);
    chk("R7 late frame not recorded", gnt_n, g(0));

    // Frame on the last sampled edge of the window (R6)
    req_n = g(4);
    nedges(3);
    req_n = NONE;
    nedges(15);
    chk("R6 grant before last edge", gnt_n, g(4));
    frame_n = 1'b0;
    irdy_n  = 1'b0;
    nedges(1);
    chk("R6 frame on last edge keeps grant", gnt_n, g(4));
    frame_n = 1'b1;
    nedges(1);
    chk("R6 held while irdy low", gnt_n, g(4));
    irdy_n = 1'b1;
    nedges(1);
    chk("R2 gap after transaction", gnt_n, NONE);
    nedges(1);
    chk("R6 parks on recorded master", gnt_n, g(4));

    // Rotating priority sweep over every last master and request pattern (R4)
    for (int l = 0; l < 6; l++) begin
      set_lam(l);
      for (int p = 1; p < 64; p++) begin
        int w;
        w = -1;
        for (int kk = 6; kk >= 1; kk--) begin
          int j;
          j = (l + kk) % 6;
          if (p[j]) w = j;
        end
        req_n = ~6'(p);
        nedges(3);
        chk("R4 rotating winner", gnt_n, g(w));
        req_n = NONE;
        nedges(22);
        chk("R7 park after sweep timeout", gnt_n, g(l));
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule